// File: doc/BRIEF.md
# Dual-Port Address Contention Arbiter

This block sits beside a two-port memory. It watches each port's active-low enable and address and flags the case where both ports are enabled on the same location. The port that reached the location first keeps it. The other port gets an active-low busy flag. That busy flag also blocks the losing port's write strobe inside the block, so a collided write never reaches the array. The block judges arrival order on rising clock edges.

A port has "arrived" once it has been enabled on its current address at the previous rising edge. A port that has just been enabled, or has just changed address, is a newcomer. The decision is recorded as an owner state and kept until the match goes away. A registered OR of the two busy conditions serves as a contention interrupt.

Top module: `dp_contention_arb`

## Requirements
- R1: When either enable is high (1), or the two addresses differ, both busy outputs are high (1).
- R2: If the left port was enabled on an address at the previous edge and the right port now becomes enabled on that same address, `rgt_busy_n` goes low in that same cycle and `lft_busy_n` stays high.
- R3: If the right port was already on the location and the left port now arrives there, by enabling or by changing its address, `lft_busy_n` goes low in that cycle and `rgt_busy_n` stays high.
- R4: When both ports start matching in the same cycle and neither had arrived before, the right port is made busy and the left port is not.
- R5: `lft_busy_n` and `rgt_busy_n` are never low at the same time.
- R6: While the match lasts, the busy side does not change. The port made busy later cannot take the location from the owner.
- R7: Busy on the losing side is released in the cycle in which the owner raises its enable or moves its address off the shared location.
- R8: A write strobe is passed to `*_wr_out` only while that side's own busy is high. A port that is busy has its write strobe forced to 0.
- R9: `clash_irq` is high in the cycle after any cycle in which a busy output was low, and low after a cycle with no busy.
- R10: After reset, both busy outputs are high and `clash_irq` is low. Neither port counts as having arrived at the first edge after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| lft_en_n | input | 1 | Left port enable, active low |
| lft_addr | input | AW | Left port address |
| lft_wr_in | input | 1 | Left port write strobe request |
| rgt_en_n | input | 1 | Right port enable, active low |
| rgt_addr | input | AW | Right port address |
| rgt_wr_in | input | 1 | Right port write strobe request |
| lft_busy_n | output | 1 | Left port busy, active low |
| rgt_busy_n | output | 1 | Right port busy, active low |
| lft_wr_out | output | 1 | Left write strobe after gating by busy |
| rgt_wr_out | output | 1 | Right write strobe after gating by busy |
| clash_irq | output | 1 | Registered OR of the two busy conditions |

## Verification
The properties assume that the inputs are settled at each rising edge, because arrival order is defined only by what the edge samples. Busy and the gated strobes are combinational from the inputs and the owner state, so the properties compare them at the same edge and need no settling margin. The bench changes inputs one time unit after a rising edge. It reads combinational outputs a few units later and reads `clash_irq` only after the following edge, which keeps every sample clear of the edge.

// File: rtl/dp_contention_arb.sv
module dp_contention_arb #(
  parameter int AW = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          lft_en_n,
  input  logic [AW-1:0] lft_addr,
  input  logic          lft_wr_in,
  input  logic          rgt_en_n,
  input  logic [AW-1:0] rgt_addr,
  input  logic          rgt_wr_in,
  output logic          lft_busy_n,
  output logic          rgt_busy_n,
  output logic          lft_wr_out,
  output logic          rgt_wr_out,
  output logic          clash_irq
);

  typedef enum logic [1:0] {OWN_NONE = 2'd0, OWN_LFT = 2'd1, OWN_RGT = 2'd2} own_e;

  own_e          owner_q, owner_d, pick;
  logic          lft_on_q, rgt_on_q;
  logic [AW-1:0] lft_addr_q, rgt_addr_q;
  logic          match, lft_settled, rgt_settled;

  assign match       = !lft_en_n && !rgt_en_n && (lft_addr == rgt_addr);
  assign lft_settled = lft_on_q && (lft_addr_q == lft_addr);
  assign rgt_settled = rgt_on_q && (rgt_addr_q == rgt_addr);

  always_comb begin
    pick = (rgt_settled && !lft_settled) ? OWN_RGT : OWN_LFT;
    if (!match)                 owner_d = OWN_NONE;
    else if (owner_q != OWN_NONE) owner_d = owner_q;
    else                        owner_d = pick;
  end

  assign lft_busy_n = (owner_d != OWN_RGT);
  assign rgt_busy_n = (owner_d != OWN_LFT);
  assign lft_wr_out = lft_wr_in && lft_busy_n;
  assign rgt_wr_out = rgt_wr_in && rgt_busy_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      owner_q    <= OWN_NONE;
      lft_on_q   <= 1'b0;
      rgt_on_q   <= 1'b0;
      lft_addr_q <= '0;
      rgt_addr_q <= '0;
      clash_irq  <= 1'b0;
    end else begin
      owner_q    <= owner_d;
      lft_on_q   <= !lft_en_n;
      rgt_on_q   <= !rgt_en_n;
      lft_addr_q <= lft_addr;
      rgt_addr_q <= rgt_addr;
      clash_irq  <= (owner_d != OWN_NONE);
    end
  end

endmodule

module dp_contention_arb_chk #(
  parameter int AW = 11
) (
  input logic          clk,
  input logic          rst_n,
  input logic          lft_en_n,
  input logic [AW-1:0] lft_addr,
  input logic          lft_wr_in,
  input logic          rgt_en_n,
  input logic [AW-1:0] rgt_addr,
  input logic          rgt_wr_in,
  input logic          lft_busy_n,
  input logic          rgt_busy_n,
  input logic          lft_wr_out,
  input logic          rgt_wr_out,
  input logic          clash_irq
);
  logic hit;
  assign hit = !lft_en_n && !rgt_en_n && (lft_addr == rgt_addr);

  AST_NEVER_BOTH_BUSY: assert property (@(posedge clk) disable iff (!rst_n) !(!lft_busy_n && !rgt_busy_n)); // R5
  AST_BUSY_NEEDS_HIT:  assert property (@(posedge clk) disable iff (!rst_n) (!lft_busy_n || !rgt_busy_n) |-> hit); // R1
  AST_LFT_WR_GATED:    assert property (@(posedge clk) disable iff (!rst_n) lft_wr_out |-> (lft_wr_in && lft_busy_n)); // R8
  AST_RGT_WR_GATED:    assert property (@(posedge clk) disable iff (!rst_n) rgt_wr_out |-> (rgt_wr_in && rgt_busy_n)); // R8
  AST_RGT_LOSS_HELD:   assert property (@(posedge clk) disable iff (!rst_n) !rgt_busy_n |=> (!hit || !rgt_busy_n)); // R6
  AST_LFT_LOSS_HELD:   assert property (@(posedge clk) disable iff (!rst_n) !lft_busy_n |=> (!hit || !lft_busy_n)); // R6
  AST_IRQ_FOLLOWS:     assert property (@(posedge clk) disable iff (!rst_n) (!lft_busy_n || !rgt_busy_n) |=> clash_irq); // R9
  AST_IRQ_QUIET:       assert property (@(posedge clk) disable iff (!rst_n) (lft_busy_n && rgt_busy_n) |=> !clash_irq); // R9
endmodule

bind dp_contention_arb dp_contention_arb_chk #(.AW(AW)) chk_i (.*);

// File: tb/dp_contention_arb_tb.sv
module dp_contention_arb_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 11;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic lft_en_n = 1'b1, rgt_en_n = 1'b1, lft_wr_in = 1'b0, rgt_wr_in = 1'b0;
  logic [AW-1:0] lft_addr = '0, rgt_addr = '0;
  logic lft_busy_n, rgt_busy_n, lft_wr_out, rgt_wr_out, clash_irq;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dp_contention_arb #(.AW(AW)) dut_i (.*);

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic drive(input logic le, input int la, input logic re, input int ra);
    lft_en_n = le; lft_addr = AW'(la); rgt_en_n = re; rgt_addr = AW'(ra);
  endtask

  task automatic idle_all();
    drive(1, 0, 1, 0); lft_wr_in = 0; rgt_wr_in = 0; step(); step();
  endtask

  task automatic t_reset();
    #2;
    chk("R10 lft busy in reset", lft_busy_n, 1);
    chk("R10 rgt busy in reset", rgt_busy_n, 1);
    chk("R10 irq in reset", clash_irq, 0);
    rst_n = 1; step();
  endtask

  task automatic t_no_match();
    drive(0, 12, 0, 13); step(); #2;
    chk("R1 diff addr lft", lft_busy_n, 1);
    chk("R1 diff addr rgt", rgt_busy_n, 1);
    drive(1, 13, 0, 13); step(); #2;
    chk("R1 lft disabled lft", lft_busy_n, 1);
    chk("R1 lft disabled rgt", rgt_busy_n, 1);
    step();
    chk("R9 irq low without busy", clash_irq, 0);
    idle_all();
  endtask

  task automatic t_left_first();
    drive(0, 5, 1, 5); step();
    drive(0, 5, 0, 5); lft_wr_in = 1; rgt_wr_in = 1; #2;
    chk("R2 rgt busy", rgt_busy_n, 0);
    chk("R2 lft free", lft_busy_n, 1);
    chk("R8 rgt write blocked", rgt_wr_out, 0);
    chk("R8 lft write passes", lft_wr_out, 1);
    step();
    chk("R9 irq after busy", clash_irq, 1);
    for (int i = 0; i < 4; i++) begin
      step(); #2;
      chk("R6 rgt stays busy", rgt_busy_n, 0);
      chk("R6 lft stays free", lft_busy_n, 1);
    end
    drive(1, 5, 0, 5); #2;
    chk("R7 released on owner disable", rgt_busy_n, 1);
    chk("R8 rgt write after release", rgt_wr_out, 1);
    step(); step();
    chk("R9 irq clears", clash_irq, 0);
    idle_all();
  endtask

  task automatic t_right_first();
    drive(0, 7, 0, 9); step();
    drive(0, 9, 0, 9); lft_wr_in = 1; #2;
    chk("R3 lft busy", lft_busy_n, 0);
    chk("R3 rgt free", rgt_busy_n, 1);
    chk("R8 lft write blocked", lft_wr_out, 0);
    step(); step(); #2;
    chk("R6 lft still busy", lft_busy_n, 0);
    drive(0, 9, 0, 10); #2;
    chk("R7 released on owner move", lft_busy_n, 1);
    idle_all();
  endtask

  task automatic t_tie();
    drive(0, 3, 0, 3); #2;
    chk("R4 tie rgt busy", rgt_busy_n, 0);
    chk("R4 tie lft free", lft_busy_n, 1);
    idle_all();
    drive(0, 20, 0, 21); step();
    drive(0, 40, 0, 40); #2;
    chk("R4 tie after moves rgt busy", rgt_busy_n, 0);
    chk("R5 not both busy", lft_busy_n | rgt_busy_n, 1);
    idle_all();
  endtask

  initial begin
    fork
      begin
        step();
        t_reset();
        t_no_match();
        t_left_first();
        t_right_first();
        t_tie();
      end
      begin
        repeat (5000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule